// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block holds a small set of transmit mailboxes and decides which one the CAN bit engine sends next. Software loads each mailbox with an identifier, a data payload and a 4-bit priority through a simple write port. It then arms the mailbox with a transfer-command write, which also carries the frame length and the remote-request flag. Among the armed mailboxes that are in transmit mode, the arbiter offers the one with the smallest priority value. When two candidates share that value, the lower mailbox number wins.

The frame is offered to the bit engine through a request/accept handshake. After acceptance, the arbiter keeps a private copy of the frame until the engine reports either completion or abort. Each mailbox exposes a ready flag and an abort flag. When a transfer ends, the mailbox's own interrupt line pulses for one cycle. While the engine is idle, the offered mailbox is re-chosen every cycle, so a more urgent arm made before acceptance still takes the slot. Once the engine has accepted a frame, that frame is never displaced.

Top module: `can_tx_arbiter`

## Requirements
- R1: After reset every mailbox reads ready (`mbxReady` all ones), no abort flag or interrupt is set, and `txReq` is low.
- R2: A control write (`wrSel`=4) with bit 23 set arms the mailbox and latches the DLC from bits 19:16 and the remote flag from bit 20. Ready drops on the next cycle. The write is ignored if the mailbox mode field (mode register bits 26:24) is not 3 (transmit), or if the mailbox is already pending.
- R3: While idle, the arbiter offers the eligible mailbox with the lowest priority value, taken from mode register bits 19:16 (0 is most urgent). Ties go to the lowest mailbox index.
- R4: The offered frame carries the selected mailbox's fields. `txId` comes from identifier register bits 28:0 and `txExt` from its bit 29. `txData` is {data-high (`wrSel`=3), data-low (`wrSel`=2)}. `txDlc` and `txRtr` are the values latched at arming.
- R5: Once `txAccept` is sampled with `txReq` high, `txReq` stays low. `txMbx` and all frame outputs stay frozen until done or abort, even if registers of that mailbox are rewritten or a more urgent mailbox is armed.
- R6: A `txDone` ends the transfer. One cycle later that mailbox is ready, its abort flag is clear, and only its `mbxIrq` bit is high, for exactly one cycle.
- R7: A `txAbort` ends the transfer with both the ready and abort flags set, and with the same one-cycle interrupt. If `txDone` and `txAbort` arrive together, the transfer counts as completed.
- R8: A write to the identifier register (`wrSel`=1) takes effect only while the mailbox mode field is 0 (disabled). Otherwise it is ignored.
- R9: Arming a mailbox clears its abort flag.
- R10: Only pending mailboxes whose mode is transmit compete. `txReq` is low when none exists, and a pending mailbox switched out of transmit mode stops being offered but stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrMbx | input | IDX_W | Target mailbox of the write |
| wrSel | input | 3 | Register select: 0 mode, 1 identifier, 2 data low, 3 data high, 4 control |
| wrData | input | WORD_W | Write data |
| txReq | output | 1 | A frame is offered to the bit engine |
| txMbx | output | IDX_W | Mailbox of the offered or in-flight frame |
| txId | output | ID_W | Frame identifier |
| txExt | output | 1 | Extended identifier flag |
| txRtr | output | 1 | Remote request flag |
| txDlc | output | DLC_W | Data length code |
| txData | output | 2*WORD_W | Payload, high word first |
| txAccept | input | 1 | Bit engine takes the offered frame |
| txDone | input | 1 | In-flight frame completed |
| txAbort | input | 1 | In-flight frame aborted |
| mbxReady | output | MBX_NUM | Per-mailbox ready (not pending) |
| mbxAbort | output | MBX_NUM | Per-mailbox aborted flag |
| mbxIrq | output | MBX_NUM | Per-mailbox end-of-transfer pulse |

## Verification
The assertions rely on the bit engine obeying the handshake:
- `txAccept` is raised only while `txReq` is high.
- `txDone` and `txAbort` are raised only after an acceptance, and at most once per transfer.

The bench drives the engine inputs only from accept and finish tasks that follow this order, and it never raises them while idle. It sweeps several priority patterns, including all-equal priorities, against every non-empty set of armed mailboxes. For each case it drains the offers one by one against a winner it computes itself.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  // register field positions shared by the datapath and the bench contract
  localparam int MODE_LSB = 24;
  localparam int MODE_W   = 3;
  localparam int PRIO_LSB = 16;
  localparam int CMD_BIT  = 23;
  localparam int RTR_BIT  = 20;
  localparam int DLC_LSB  = 16;
  localparam int EXT_BIT  = 29;

  localparam logic [MODE_W-1:0] MODE_OFF = 3'd0;
  localparam logic [MODE_W-1:0] MODE_TX  = 3'd3;

  typedef enum logic [2:0] {
    SEL_MODE = 3'd0,
    SEL_ID   = 3'd1,
    SEL_DLO  = 3'd2,
    SEL_DHI  = 3'd3,
    SEL_CTRL = 3'd4
  } regSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;
    logic finish;
    logic fail;
    logic busy;
  } ctrlStb_t;
endpackage

// File: rtl/can_arb_pick.sv
module can_arb_pick #(
  parameter int MBX_NUM = 4,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(MBX_NUM)
) (
  input  logic [MBX_NUM-1:0] elig,
  input  logic [PRIO_W-1:0]  prio [MBX_NUM],
  output logic               found,
  output logic [IDX_W-1:0]   selIdx
);
  logic [PRIO_W-1:0] best;

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    best   = '1;
    for (int i = 0; i < MBX_NUM; i++) begin
      if (elig[i] && (!found || prio[i] < best)) begin
        found  = 1'b1;
        selIdx = IDX_W'(i);
        best   = prio[i];
      end
    end
  end
endmodule

// File: rtl/can_arb_ctrl.sv
module can_arb_ctrl
  import can_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     anyElig,
  input  logic     txAccept,
  input  logic     txDone,
  input  logic     txAbort,
  output logic     txReq,
  output ctrlStb_t stb
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t stateQ, stateD;

  always_comb begin
    stateD     = stateQ;
    txReq      = (stateQ == ST_IDLE) && anyElig;
    stb.busy   = (stateQ == ST_BUSY);
    stb.launch = txReq && txAccept;
    stb.finish = stb.busy && txDone;
    stb.fail   = stb.busy && txAbort && !txDone;
    if (stb.launch)
      stateD = ST_BUSY;
    else if (stb.finish || stb.fail)
      stateD = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R5
  no_reoffer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && txAccept) |=> !txReq);
endmodule

// File: rtl/can_arb_dp.sv
module can_arb_dp
  import can_arb_pkg::*;
#(
  parameter int MBX_NUM = 4,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 29,
  parameter int DLC_W   = 4,
  parameter int WORD_W  = 32,
  localparam int IDX_W  = $clog2(MBX_NUM)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrMbx,
  input  logic [2:0]          wrSel,
  input  logic [WORD_W-1:0]   wrData,
  input  ctrlStb_t            stb,
  output logic                anyElig,
  output logic [IDX_W-1:0]    txMbx,
  output logic [ID_W-1:0]     txId,
  output logic                txExt,
  output logic                txRtr,
  output logic [DLC_W-1:0]    txDlc,
  output logic [2*WORD_W-1:0] txData,
  output logic [MBX_NUM-1:0]  mbxReady,
  output logic [MBX_NUM-1:0]  mbxAbort,
  output logic [MBX_NUM-1:0]  mbxIrq
);
  logic [MODE_W-1:0] modeQ  [MBX_NUM];
  logic [PRIO_W-1:0] prioQ  [MBX_NUM];
  logic [ID_W-1:0]   idQ    [MBX_NUM];
  logic              extQ   [MBX_NUM];
  logic [WORD_W-1:0] loQ    [MBX_NUM];
  logic [WORD_W-1:0] hiQ    [MBX_NUM];
  logic [DLC_W-1:0]  dlcQ   [MBX_NUM];
  logic              rtrQ   [MBX_NUM];
  logic              pendQ  [MBX_NUM];
  logic              abortQ [MBX_NUM];
  logic              irqQ   [MBX_NUM];
  logic [MBX_NUM-1:0] elig;

  logic [IDX_W-1:0]    selIdx;
  logic [IDX_W-1:0]    flyIdx;
  logic [ID_W-1:0]     flyId;
  logic                flyExt;
  logic                flyRtr;
  logic [DLC_W-1:0]    flyDlc;
  logic [2*WORD_W-1:0] flyData;

  for (genvar g = 0; g < MBX_NUM; g++) begin : g_mbx
    logic hit, armOk, endHit;
    assign hit    = wrEn && (wrMbx == IDX_W'(g));
    assign armOk  = hit && (wrSel == SEL_CTRL) && wrData[CMD_BIT]
                    && (modeQ[g] == MODE_TX) && !pendQ[g];
    assign endHit = (stb.finish || stb.fail) && (flyIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeQ[g]  <= MODE_OFF;
        prioQ[g]  <= '0;
        idQ[g]    <= '0;
        extQ[g]   <= 1'b0;
        loQ[g]    <= '0;
        hiQ[g]    <= '0;
        dlcQ[g]   <= '0;
        rtrQ[g]   <= 1'b0;
        pendQ[g]  <= 1'b0;
        abortQ[g] <= 1'b0;
        irqQ[g]   <= 1'b0;
      end else begin
        irqQ[g] <= endHit;
        if (hit && wrSel == SEL_MODE) begin
          modeQ[g] <= wrData[MODE_LSB +: MODE_W];
          prioQ[g] <= wrData[PRIO_LSB +: PRIO_W];
        end
        if (hit && wrSel == SEL_ID && modeQ[g] == MODE_OFF) begin
          idQ[g]  <= wrData[ID_W-1:0];
          extQ[g] <= wrData[EXT_BIT];
        end
        if (hit && wrSel == SEL_DLO) loQ[g] <= wrData;
        if (hit && wrSel == SEL_DHI) hiQ[g] <= wrData;
        if (armOk) begin
          pendQ[g]  <= 1'b1;
          abortQ[g] <= 1'b0;
          dlcQ[g]   <= wrData[DLC_LSB +: DLC_W];
          rtrQ[g]   <= wrData[RTR_BIT];
        end else if (endHit) begin
          pendQ[g]  <= 1'b0;
          abortQ[g] <= stb.fail;
        end
      end
    end

    assign elig[g]     = pendQ[g] && (modeQ[g] == MODE_TX);
    assign mbxReady[g] = !pendQ[g];
    assign mbxAbort[g] = abortQ[g];
    assign mbxIrq[g]   = irqQ[g];

    // R3
    pick_order_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!stb.busy && anyElig && elig[g]) |->
        (prioQ[txMbx] < prioQ[g]) ||
        ((prioQ[txMbx] == prioQ[g]) && (txMbx <= IDX_W'(g))));
  end

  can_arb_pick #(.MBX_NUM(MBX_NUM), .PRIO_W(PRIO_W)) i_pick (
    .elig   (elig),
    .prio   (prioQ),
    .found  (anyElig),
    .selIdx (selIdx)
  );

  // private copy of the accepted frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flyIdx  <= '0;
      flyId   <= '0;
      flyExt  <= 1'b0;
      flyRtr  <= 1'b0;
      flyDlc  <= '0;
      flyData <= '0;
    end else if (stb.launch) begin
      flyIdx  <= selIdx;
      flyId   <= idQ[selIdx];
      flyExt  <= extQ[selIdx];
      flyRtr  <= rtrQ[selIdx];
      flyDlc  <= dlcQ[selIdx];
      flyData <= {hiQ[selIdx], loQ[selIdx]};
    end
  end

  always_comb begin
    if (stb.busy) begin
      txMbx  = flyIdx;
      txId   = flyId;
      txExt  = flyExt;
      txRtr  = flyRtr;
      txDlc  = flyDlc;
      txData = flyData;
    end else begin
      txMbx  = selIdx;
      txId   = idQ[selIdx];
      txExt  = extQ[selIdx];
      txRtr  = rtrQ[selIdx];
      txDlc  = dlcQ[selIdx];
      txData = {hiQ[selIdx], loQ[selIdx]};
    end
  end

  // R5
  hold_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busy && !stb.finish && !stb.fail) |=>
      ($stable(txMbx) && $stable(txData) && $stable(txId) && $stable(txDlc)));

  // R6
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mbxIrq));

  // R6
  irq_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mbxIrq & ~mbxReady) == '0);

  // R7
  abort_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mbxAbort & ~mbxReady) == '0);
endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter
  import can_arb_pkg::*;
#(
  parameter int MBX_NUM = 4,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 29,
  parameter int DLC_W   = 4,
  parameter int WORD_W  = 32,
  localparam int IDX_W  = $clog2(MBX_NUM)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrMbx,
  input  logic [2:0]          wrSel,
  input  logic [WORD_W-1:0]   wrData,
  output logic                txReq,
  output logic [IDX_W-1:0]    txMbx,
  output logic [ID_W-1:0]     txId,
  output logic                txExt,
  output logic                txRtr,
  output logic [DLC_W-1:0]    txDlc,
  output logic [2*WORD_W-1:0] txData,
  input  logic                txAccept,
  input  logic                txDone,
  input  logic                txAbort,
  output logic [MBX_NUM-1:0]  mbxReady,
  output logic [MBX_NUM-1:0]  mbxAbort,
  output logic [MBX_NUM-1:0]  mbxIrq
);
  ctrlStb_t stb;
  logic     anyElig;

  can_arb_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyElig  (anyElig),
    .txAccept (txAccept),
    .txDone   (txDone),
    .txAbort  (txAbort),
    .txReq    (txReq),
    .stb      (stb)
  );

  can_arb_dp #(
    .MBX_NUM (MBX_NUM),
    .PRIO_W  (PRIO_W),
    .ID_W    (ID_W),
    .DLC_W   (DLC_W),
    .WORD_W  (WORD_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrMbx    (wrMbx),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .stb      (stb),
    .anyElig  (anyElig),
    .txMbx    (txMbx),
    .txId     (txId),
    .txExt    (txExt),
    .txRtr    (txRtr),
    .txDlc    (txDlc),
    .txData   (txData),
    .mbxReady (mbxReady),
    .mbxAbort (mbxAbort),
    .mbxIrq   (mbxIrq)
  );

  // R10
  offer_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> !mbxReady[txMbx]);
endmodule

// File: tb/test_can_tx_arbiter.sv
module test_can_tx_arbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrMbx = '0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic        txAccept = 1'b0, txDone = 1'b0, txAbort = 1'b0;
  logic        txReq, txExt, txRtr;
  logic [1:0]  txMbx;
  logic [28:0] txId;
  logic [3:0]  txDlc;
  logic [63:0] txData;
  logic [3:0]  mbxReady, mbxAbort, mbxIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [28:0] expId  [4];
  logic        expExt [4];
  logic [31:0] expLo  [4];
  logic [31:0] expHi  [4];
  logic [3:0]  expDlc [4];
  logic        expRtr [4];
  int          pr     [4];

  always #5 clk = ~clk;

  can_tx_arbiter i_can_tx_arbiter (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMbx(wrMbx), .wrSel(wrSel),
    .wrData(wrData), .txReq(txReq), .txMbx(txMbx), .txId(txId),
    .txExt(txExt), .txRtr(txRtr), .txDlc(txDlc), .txData(txData),
    .txAccept(txAccept), .txDone(txDone), .txAbort(txAbort),
    .mbxReady(mbxReady), .mbxAbort(mbxAbort), .mbxIrq(mbxIrq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int m, input int s, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrMbx = 2'(m); wrSel = 3'(s); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setMode(input int m, input int mode, input int prio);
    wr(m, 0, (32'(mode) << 24) | (32'(prio) << 16));
  endtask

  task automatic arm(input int m, input int dlc, input int rtr);
    wr(m, 4, (32'd1 << 23) | (32'(rtr) << 20) | (32'(dlc) << 16));
  endtask

  task automatic accept();
    @(negedge clk); txAccept = 1'b1;
    @(negedge clk); txAccept = 1'b0;
  endtask

  task automatic finish(input bit ab, input bit dn);
    @(negedge clk); txDone = dn; txAbort = ab;
    @(negedge clk); txDone = 1'b0; txAbort = 1'b0;
  endtask

  task automatic checkFrame(input string tag, input int m);
    chk({tag, " txMbx"},  64'(txMbx),  64'(m));
    chk({tag, " txId"},   64'(txId),   64'(expId[m]));
    chk({tag, " txExt"},  64'(txExt),  64'(expExt[m]));
    chk({tag, " txData"}, txData,      {expHi[m], expLo[m]});
    chk({tag, " txDlc"},  64'(txDlc),  64'(expDlc[m]));
    chk({tag, " txRtr"},  64'(txRtr),  64'(expRtr[m]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    chk("R1 ready", 64'(mbxReady), 64'hF);
    chk("R1 abort", 64'(mbxAbort), 64'h0);
    chk("R1 irq",   64'(mbxIrq),   64'h0);
    chk("R1 txReq", 64'(txReq),    64'h0);

    for (int i = 0; i < 4; i++) begin
      expId[i]  = 29'((i + 1) * 32'h0123_4567);
      expExt[i] = i[0];
      expLo[i]  = 32'hA000_0000 + 32'(i);
      expHi[i]  = 32'h5B00_0000 + 32'(i * 3);
      setMode(i, 0, 0);
      wr(i, 1, {2'b00, expExt[i], expId[i]});
      wr(i, 2, expLo[i]);
      wr(i, 3, expHi[i]);
    end

    // R2 arm ignored while disabled
    arm(0, 3, 1);
    chk("R2 disabled arm ready", 64'(mbxReady), 64'hF);
    chk("R2 disabled arm txReq", 64'(txReq), 64'h0);

    setMode(0, 3, 3);
    arm(0, 3, 1);
    expDlc[0] = 4'd3; expRtr[0] = 1'b1;
    chk("R2 armed ready", 64'(mbxReady), 64'hE);
    chk("R2 txReq", 64'(txReq), 64'h1);
    checkFrame("R2 R4 mb0", 0);
    arm(0, 7, 0);
    chk("R2 rearm pending ignored dlc", 64'(txDlc), 64'd3);

    // R8 id write ignored in transmit mode
    setMode(1, 3, 0);
    wr(1, 1, 32'h2ABC_DEF0);

    // R5 no preemption
    accept();
    chk("R5 txReq low in flight", 64'(txReq), 64'h0);
    arm(1, 2, 0);
    expDlc[1] = 4'd2; expRtr[1] = 1'b0;
    chk("R5 still mb0", 64'(txMbx), 64'd0);
    chk("R5 txReq low", 64'(txReq), 64'h0);
    wr(0, 2, 32'hDEAD_BEEF);
    chk("R5 frozen data", txData, {expHi[0], expLo[0]});
    expLo[0] = 32'hDEAD_BEEF;

    // R6 completion
    finish(0, 1);
    chk("R6 irq", 64'(mbxIrq), 64'h1);
    chk("R6 ready", 64'(mbxReady), 64'hD);
    chk("R6 abort", 64'(mbxAbort), 64'h0);
    @(negedge clk);
    chk("R6 irq one cycle", 64'(mbxIrq), 64'h0);
    chk("R8 txReq", 64'(txReq), 64'h1);
    checkFrame("R8 old id kept", 1);

    // R7 abort
    accept();
    finish(1, 0);
    chk("R7 abort flag", 64'(mbxAbort), 64'h2);
    chk("R7 ready", 64'(mbxReady), 64'hF);
    chk("R7 irq", 64'(mbxIrq), 64'h2);

    // R9 re-arm clears abort
    arm(1, 2, 0);
    chk("R9 abort cleared", 64'(mbxAbort), 64'h0);
    chk("R9 ready", 64'(mbxReady), 64'hD);
    accept();
    finish(1, 1);
    chk("R7 done wins abort", 64'(mbxAbort), 64'h0);
    chk("R7 done wins ready", 64'(mbxReady), 64'hF);
    chk("R7 done wins irq", 64'(mbxIrq), 64'h2);

    // R10 eligibility follows mode
    setMode(3, 3, 0);
    arm(3, 1, 0);
    expDlc[3] = 4'd1; expRtr[3] = 1'b0;
    chk("R10 offered", 64'(txReq), 64'h1);
    chk("R10 mbx", 64'(txMbx), 64'd3);
    setMode(3, 0, 0);
    chk("R10 not offered when disabled", 64'(txReq), 64'h0);
    chk("R10 still pending", 64'(mbxReady), 64'h7);
    setMode(3, 3, 0);
    chk("R10 offered again", 64'(txReq), 64'h1);
    accept();
    finish(0, 1);
    chk("R10 drained", 64'(txReq), 64'h0);

    // R3 R4 sweep over priority patterns and armed sets
    for (int p = 0; p < 9; p++) begin
      for (int i = 0; i < 4; i++) begin
        pr[i] = (p == 8) ? 5 : ((p * 7 + i * 5) % 16);
        setMode(i, 3, pr[i]);
      end
      for (int mask = 1; mask < 16; mask++) begin
        int remaining;
        remaining = mask;
        for (int i = 0; i < 4; i++) begin
          if (mask[i]) begin
            expDlc[i] = 4'((i + mask) % 9);
            expRtr[i] = mask[(i + 1) % 4];
            arm(i, int'(expDlc[i]), int'(expRtr[i]));
          end
        end
        while (remaining != 0) begin
          int w;
          w = -1;
          for (int i = 0; i < 4; i++)
            if (remaining[i] && (w < 0 || pr[i] < pr[w])) w = i;
          chk("R3 txReq", 64'(txReq), 64'h1);
          checkFrame("R3 R4 winner", w);
          accept();
          finish(0, 1);
          chk("R6 sweep irq", 64'(mbxIrq), 64'(1 << w));
          remaining = remaining & ~(1 << w);
          chk("R6 sweep ready", 64'(mbxReady), 64'(4'hF & ~remaining));
        end
        chk("R10 sweep idle", 64'(txReq), 64'h0);
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule